// File: doc/BRIEF.md
# NaN Format Converter (half / single / double)

This unit takes a floating-point word that is already known to be a NaN and
re-encodes it in another binary format: half (16-bit), single (32-bit) or
double (64-bit). The payload is first lifted into a 64-bit left-justified
working form, and the sign is kept beside it. It is then cut down to the
fraction width of the target format and rebuilt with an all-ones exponent.
If nothing of the payload survives the cut, or the default-NaN mode is
requested, the unit emits the target format's default NaN instead.

The meaning of the top fraction bit can be selected. With the polarity
input low, a clear top bit marks a signaling NaN. With the polarity input
high, a set top bit marks a signaling NaN. The default NaN pattern follows
the same choice. Converting a signaling source raises the invalid flag. The
payload is carried as it is and is not quietened. A request is taken when
`in_valid` is high, and the result appears on the registered outputs one
clock later.

Top module: `nan_fmt_conv`

## Requirements
- R1: After a cycle with `rst_n` low, `out_valid`, `out_invalid` and `out_word` are all zero.
- R2: `out_valid` is high exactly in the cycle after one in which `in_valid` was high. When `in_valid` is low, `out_word` and `out_invalid` hold their previous values.
- R3: With `snan_pol` = 0, a source is signaling when its exponent is all ones, its top fraction bit is 0 and some lower fraction bit is 1. Such a source sets `out_invalid`, and a source with the top fraction bit set leaves it clear.
- R4: With `snan_pol` = 1, a source is signaling when its exponent is all ones and its top fraction bit is 1. Such a source sets `out_invalid`, and a source with that bit clear leaves it clear.
- R5: For a conversion to a wider format, the result carries the source sign and an all-ones exponent. The source fraction sits at the top of the destination fraction, and the bits below it are zero.
- R6: For a conversion to a narrower format, the result keeps the top destination-width bits of the source fraction and drops the rest.
- R7: If the kept fraction bits are all zero, the result is the destination default NaN (sign clear). `out_invalid` still reflects the source.
- R8: With `dflt_mode` = 1, the result is always the destination default NaN, and `out_invalid` still reflects the source.
- R9: With `snan_pol` = 0, the default NaNs are 0x7E00 (half), 0x7FC00000 (single) and 0x7FF8000000000000 (double).
- R10: With `snan_pol` = 1, the default NaNs are 0x7DFF (half), 0x7FBFFFFF (single) and 0x7FF7FFFFFFFFFFFF (double).
- R11: Format codes are 00 = half, 01 = single, 10 = double, and 11 is reserved. A reserved source gives the destination default NaN with `out_invalid` clear. A reserved destination gives an all-zero word.
- R12: `src_word` bits above the source width are ignored, and `out_word` bits above the destination width are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; the inputs are sampled when it is high |
| src_word | input | 64 | Source NaN, right-aligned in the bus |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| snan_pol | input | 1 | Top-fraction-bit polarity: 0 = set means quiet, 1 = set means signaling |
| dflt_mode | input | 1 | Forces the default NaN result |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_word | output | 64 | Converted NaN, right-aligned |
| out_invalid | output | 1 | Invalid flag: the source was signaling |

## Verification
The checker watches the handshake on every cycle. It checks that `out_valid` tracks the previous `in_valid` and that the outputs hold while idle. It also checks that a double destination always shows an all-ones exponent and that a half destination leaves the upper bits clear. It further checks that a reserved source never raises the invalid flag and that the forced single-precision default appears when requested. The exact payload placement under widening and narrowing, the truncation-to-zero fallback, and both polarity classifications depend on specific bit patterns. Only the bench's directed scenarios, with hand-computed results, can show those.

// File: rtl/nanconv_pkg.sv
// Shared definitions for the NaN format converter.
// Assumes a 64-bit working form; format geometry is derived from the code.
package nanconv_pkg;

    localparam int CANON_W = 64;          // width of the left-justified working form
    localparam int SHW     = 7;           // width of shift/size quantities (holds CANON_W)

    typedef enum logic [1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    // Fraction field width of a format (reserved code falls back to double geometry)
    function automatic logic [SHW-1:0] frac_bits(input fmt_e f);
        case (f)
            FMT_HALF:   return SHW'(10);
            FMT_SINGLE: return SHW'(23);
            default:    return SHW'(52);
        endcase
    endfunction

    // Exponent field width of a format
    function automatic logic [SHW-1:0] exp_bits(input fmt_e f);
        case (f)
            FMT_HALF:   return SHW'(5);
            FMT_SINGLE: return SHW'(8);
            default:    return SHW'(11);
        endcase
    endfunction

endpackage

// File: rtl/nan_unpack.sv
// Splits a source NaN into sign and left-justified payload, and classifies it.
// Assumes the input is a NaN; bits above the format width are ignored.
module nan_unpack
    import nanconv_pkg::*;
(
    input  logic [CANON_W-1:0] word_i,
    input  fmt_e               fmt_i,
    input  logic               pol_i,
    output logic               sign_o,
    output logic [CANON_W-1:0] pay_o,
    output logic               snan_o,
    output logic               fmt_ok_o
);

    logic [SHW-1:0]     fw;
    logic [SHW-1:0]     ew;
    logic [CANON_W-1:0] exp_mask;
    logic [CANON_W-1:0] frac;
    logic [CANON_W-1:0] low_mask;
    logic [CANON_W-1:0] sign_shift;
    logic               exp_ones;
    logic               top_bit;
    logic               low_nz;

    // Field extraction, payload alignment and signaling test
    always_comb begin
        fw         = frac_bits(fmt_i);
        ew         = exp_bits(fmt_i);
        fmt_ok_o   = (fmt_i != FMT_RSVD);
        exp_mask   = (CANON_W'(1) << ew) - CANON_W'(1);
        frac       = word_i & ((CANON_W'(1) << fw) - CANON_W'(1));
        low_mask   = (CANON_W'(1) << (fw - SHW'(1))) - CANON_W'(1);
        exp_ones   = ((word_i >> fw) & exp_mask) == exp_mask;
        top_bit    = |(frac & ~low_mask);
        low_nz     = |(frac & low_mask);
        sign_shift = word_i >> (fw + ew);
        sign_o     = sign_shift[0];
        pay_o      = frac << (SHW'(CANON_W) - fw);
        if (pol_i) begin
            snan_o = fmt_ok_o & exp_ones & top_bit;
        end else begin
            snan_o = fmt_ok_o & exp_ones & ~top_bit & low_nz;
        end
    end

endmodule

// File: rtl/nan_dflt_gen.sv
// Produces the default NaN of a destination format for either polarity.
// Assumes a valid format code; the caller handles the reserved code.
module nan_dflt_gen
    import nanconv_pkg::*;
(
    input  fmt_e               fmt_i,
    input  logic               pol_i,
    output logic [CANON_W-1:0] dflt_o
);

    logic [SHW-1:0]     fw;
    logic [SHW-1:0]     ew;
    logic [CANON_W-1:0] exp_field;
    logic [CANON_W-1:0] top_frac;

    // Default pattern: positive, all-ones exponent, polarity-dependent fraction
    always_comb begin
        fw        = frac_bits(fmt_i);
        ew        = exp_bits(fmt_i);
        exp_field = ((CANON_W'(1) << ew) - CANON_W'(1)) << fw;
        top_frac  = CANON_W'(1) << (fw - SHW'(1));
        dflt_o    = pol_i ? (exp_field | (top_frac - CANON_W'(1)))
                          : (exp_field | top_frac);
    end

endmodule

// File: rtl/nan_pack.sv
// Rebuilds a NaN in the destination format from sign and left-justified payload.
// Falls back to the default NaN when forced or when the kept payload is zero.
module nan_pack
    import nanconv_pkg::*;
(
    input  logic               sign_i,
    input  logic [CANON_W-1:0] pay_i,
    input  fmt_e               fmt_i,
    input  logic               pol_i,
    input  logic               force_dflt_i,
    output logic [CANON_W-1:0] word_o
);

    logic [SHW-1:0]     fw;
    logic [SHW-1:0]     ew;
    logic [CANON_W-1:0] mant;
    logic [CANON_W-1:0] exp_field;
    logic [CANON_W-1:0] built;
    logic [CANON_W-1:0] dflt;

    nan_dflt_gen u_dflt (
        .fmt_i  (fmt_i),
        .pol_i  (pol_i),
        .dflt_o (dflt)
    );

    // Truncate payload, assemble fields, choose the final pattern
    always_comb begin
        fw        = frac_bits(fmt_i);
        ew        = exp_bits(fmt_i);
        mant      = pay_i >> (SHW'(CANON_W) - fw);
        exp_field = ((CANON_W'(1) << ew) - CANON_W'(1)) << fw;
        built     = (CANON_W'(sign_i) << (fw + ew)) | exp_field | mant;
        if (fmt_i == FMT_RSVD) begin
            word_o = '0;
        end else if (force_dflt_i || (mant == '0)) begin
            word_o = dflt;
        end else begin
            word_o = built;
        end
    end

endmodule

// File: rtl/nan_fmt_conv.sv
// Top level: NaN conversion between half, single and double with one register stage.
// Assumes src_word holds a NaN of the selected source format.
module nan_fmt_conv
    import nanconv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [CANON_W-1:0]  src_word,
    input  logic [1:0]          src_fmt,
    input  logic [1:0]          dst_fmt,
    input  logic                snan_pol,
    input  logic                dflt_mode,
    output logic                out_valid,
    output logic [CANON_W-1:0]  out_word,
    output logic                out_invalid
);

    logic               c_sign;
    logic [CANON_W-1:0] c_pay;
    logic               c_snan;
    logic               c_src_ok;
    logic [CANON_W-1:0] c_word;

    nan_unpack u_unpack (
        .word_i   (src_word),
        .fmt_i    (fmt_e'(src_fmt)),
        .pol_i    (snan_pol),
        .sign_o   (c_sign),
        .pay_o    (c_pay),
        .snan_o   (c_snan),
        .fmt_ok_o (c_src_ok)
    );

    nan_pack u_pack (
        .sign_i       (c_sign),
        .pay_i        (c_pay),
        .fmt_i        (fmt_e'(dst_fmt)),
        .pol_i        (snan_pol),
        .force_dflt_i (dflt_mode | ~c_src_ok),
        .word_o       (c_word)
    );

    // Output register: capture the result on a request, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_word    <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word    <= c_word;
                out_invalid <= c_snan;
            end
        end
    end

endmodule

// File: rtl/nan_fmt_conv_chk.sv
// Cycle-level checks on the converter's ports, attached by bind.
module nan_fmt_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] src_word,
    input logic [1:0]  src_fmt,
    input logic [1:0]  dst_fmt,
    input logic        snan_pol,
    input logic        dflt_mode,
    input logic        out_valid,
    input logic [63:0] out_word,
    input logic        out_invalid
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_word) && $stable(out_invalid)));

    // R12
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_fmt == 2'b00) |=> (out_word[63:16] == 48'h0));

    // R5
    double_exp_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_fmt == 2'b10) |=> (&out_word[62:52]));

    // R11
    rsvd_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_fmt == 2'b11) |=> !out_invalid);

    // R8
    forced_single_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dflt_mode && !snan_pol && dst_fmt == 2'b01)
        |=> (out_word == 64'h0000_0000_7FC0_0000));

endmodule

bind nan_fmt_conv nan_fmt_conv_chk u_chk (.*);

// File: tb/test_nan_fmt_conv.sv
module test_nan_fmt_conv;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] src_word;
    logic [1:0]  src_fmt;
    logic [1:0]  dst_fmt;
    logic        snan_pol;
    logic        dflt_mode;
    logic        out_valid;
    logic [63:0] out_word;
    logic        out_invalid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [1:0] H = 2'b00, S = 2'b01, D = 2'b10, X = 2'b11;

    always #4 clk = ~clk;   // 125 MHz

    nan_fmt_conv i_nan_fmt_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
        .src_fmt(src_fmt), .dst_fmt(dst_fmt), .snan_pol(snan_pol),
        .dflt_mode(dflt_mode), .out_valid(out_valid), .out_word(out_word),
        .out_invalid(out_invalid)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request and check the registered result one cycle later
    task automatic conv(input string req, input logic [63:0] w, input logic [1:0] sf,
                        input logic [1:0] df, input logic pol, input logic dm,
                        input logic [63:0] exp_w, input logic exp_inv);
        @(negedge clk);
        src_word = w; src_fmt = sf; dst_fmt = df; snan_pol = pol; dflt_mode = dm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check64({req, " valid"}, 64'(out_valid), 64'd1);
        check64({req, " word"}, out_word, exp_w);
        check64({req, " invalid"}, 64'(out_invalid), 64'(exp_inv));
    endtask

    task automatic t_reset();   // R1
        rst_n = 1'b0; in_valid = 1'b0; src_word = '0; src_fmt = S; dst_fmt = S;
        snan_pol = 1'b0; dflt_mode = 1'b0;
        repeat (3) @(negedge clk);
        check64("R1 out_valid", 64'(out_valid), 64'd0);
        check64("R1 out_word", out_word, 64'd0);
        check64("R1 out_invalid", 64'(out_invalid), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_widen();   // R5
        conv("R5 single->double", 64'hFFC1_2345, S, D, 1'b0, 1'b0, 64'hFFF8_2468_A000_0000, 1'b0);
        conv("R5 half->double pol1", 64'h7C01, H, D, 1'b1, 1'b0, 64'h7FF0_0400_0000_0000, 1'b0);
    endtask

    task automatic t_narrow();  // R6
        conv("R6 double->single", 64'h7FFA_BCDE_1234_5678, D, S, 1'b0, 1'b0, 64'h7FD5_E6F0, 1'b0);
        conv("R6 double->half", 64'h7FFA_BCDE_1234_5678, D, H, 1'b0, 1'b0, 64'h7EAF, 1'b0);
    endtask

    task automatic t_snan_pol0();   // R3, R7
        conv("R3 snan single->double", 64'h7F80_0001, S, D, 1'b0, 1'b0, 64'h7FF0_0000_2000_0000, 1'b1);
        conv("R7 snan truncated to half", 64'h7F80_0001, S, H, 1'b0, 1'b0, 64'h7E00, 1'b1);
    endtask

    task automatic t_snan_pol1();   // R4
        conv("R4 pol1 signaling half->single", 64'h7E01, H, S, 1'b1, 1'b0, 64'h7FC0_2000, 1'b1);
    endtask

    task automatic t_defaults();    // R8, R9, R10
        conv("R8 forced with snan", 64'hFF80_0001, S, H, 1'b0, 1'b1, 64'h7E00, 1'b1);
        conv("R9 single default", 64'h7FC1_2345, S, S, 1'b0, 1'b1, 64'h7FC0_0000, 1'b0);
        conv("R9 double default", 64'h7FC1_2345, S, D, 1'b0, 1'b1, 64'h7FF8_0000_0000_0000, 1'b0);
        conv("R10 half default", 64'h7C01, H, H, 1'b1, 1'b1, 64'h7DFF, 1'b0);
        conv("R10 single default", 64'h7C01, H, S, 1'b1, 1'b1, 64'h7FBF_FFFF, 1'b0);
        conv("R10 double default", 64'h7C01, H, D, 1'b1, 1'b1, 64'h7FF7_FFFF_FFFF_FFFF, 1'b0);
    endtask

    task automatic t_reserved();    // R11
        conv("R11 reserved source", 64'h7F80_0001, X, S, 1'b0, 1'b0, 64'h7FC0_0000, 1'b0);
        conv("R11 reserved destination", 64'h7FC1_2345, S, X, 1'b0, 1'b0, 64'h0, 1'b0);
    endtask

    task automatic t_upper_bits();  // R12
        conv("R12 half with upper garbage", 64'hDEAD_BEEF_1234_FE00, H, S, 1'b0, 1'b0, 64'hFFC0_0000, 1'b0);
    endtask

    task automatic t_idle();        // R2
        conv("R2 setup", 64'h7F80_0001, S, D, 1'b0, 1'b0, 64'h7FF0_0000_2000_0000, 1'b1);
        src_word = 64'h7E01; src_fmt = H; dst_fmt = H; snan_pol = 1'b1;
        @(negedge clk);
        check64("R2 idle valid low", 64'(out_valid), 64'd0);
        check64("R2 idle word held", out_word, 64'h7FF0_0000_2000_0000);
        check64("R2 idle invalid held", 64'(out_invalid), 64'd1);
    endtask

    initial begin
        t_reset();
        t_widen();
        t_narrow();
        t_snan_pol0();
        t_snan_pol1();
        t_defaults();
        t_reserved();
        t_upper_bits();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule